// File: doc/BRIEF.md
# Link Speed Bring-up Sequencer

This block drives the bring-up of a serial link in two stages. On a start pulse it first limits the advertised maximum link speed to generation 1. Only then does it switch on the training state machine. It waits for the link to report up. A strap can hold the link at generation 1; with the strap low, the block raises the advertised maximum to generation 2 and issues a directed speed-change request. It then waits for the hardware to clear that request, waits for link-up a second time, and reports done.

Every wait is a bounded poll. The block samples the awaited condition once every `POLL_GAP` cycles and gives up after `POLL_LIMIT` samples, which ends the sequence with a sticky error. The training logic and the register file are outside this block. The block only drives the 4-bit maximum-speed field, the training enable and the speed-change request bit, and it observes link-up and the hardware clear of the request.

Top module: `speed_bringup_seq`

## Requirements
- R1: After reset, `max_speed_o` holds `RESET_SPEED` (default code 2), and `train_en_o`, `spdchg_req_o`, `done_o` and `error_o` are 0. `cur_gen_o` is 0.
- R2: An accepted start sets `max_speed_o` to code 1 (generation 1), clears `train_en_o`, `done_o`, `error_o`, `cur_gen_o` and any pending request on the next clock edge. `train_en_o` rises one cycle later, so the cap is always in place first.
- R3: `link_up_i` is sampled first on the clock edge that ends the first cycle of `train_en_o` being high, then every `POLL_GAP` cycles, for at most `POLL_LIMIT` samples. If no sample sees it high, `error_o` is set on the edge of the last sample, which is 1+(POLL_LIMIT-1)*POLL_GAP cycles after `train_en_o` rose.
- R4: With `force_gen1_i` high, the first link-up ends the sequence. `done_o` is 1, `max_speed_o` stays code 1, `cur_gen_o` is 1, and no speed-change request is ever issued.
- R5: With `force_gen1_i` low, the first link-up rewrites `max_speed_o` to code 2 (generation 2) and sets `cur_gen_o` to 1. `spdchg_req_o` is set one cycle later.
- R6: `spdchg_req_o` stays high until `spdchg_clr_i` is seen high. The block polls for the request bit reading 0 under the same rate and limit as R3. If the bit is still 1 after the last sample, the block sets `error_o` and leaves the request set.
- R7: After the request clears, link-up is awaited a second time with the same bounds. On success `done_o` is set and `cur_gen_o` becomes 2. On timeout `error_o` is set and `cur_gen_o` stays 1.
- R8: `done_o` and `error_o` are never high together. Each stays high until the next accepted start.
- R9: A start pulse while the sequence is running has no effect: `train_en_o` stays high, `max_speed_o` is unchanged, and the run finishes as it would have without the pulse.
- R10: A link-up first seen on the last allowed sample still counts as success. One cycle later it gives an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted only when idle, done or failed |
| force_gen1_i | input | 1 | Strap: skip the generation 2 upgrade |
| link_up_i | input | 1 | Link-up indication from the training logic |
| spdchg_clr_i | input | 1 | Hardware clears the speed-change request |
| max_speed_o | output | 4 | Advertised maximum speed field (1 = gen1, 2 = gen2) |
| train_en_o | output | 1 | Training state machine enable |
| spdchg_req_o | output | 1 | Directed speed-change request bit |
| cur_gen_o | output | 4 | Generation reached by the sequence (0 = none) |
| done_o | output | 1 | Sticky success flag |
| error_o | output | 1 | Sticky failure flag |

## Verification
The assertions check the ordering rules on every cycle:
- the cap is in place before training is enabled;
- an upgrade happens only after a sampled link-up with the strap low;
- a request is issued only at generation 2;
- done follows a sampled link-up;
- the flags are exclusive and sticky;
- a start during a run never drops the training enable.

The exact poll timing can only be shown by the bench scenarios. These cover the error latency, the last-sample boundary and the one-cycle-late miss. The bench scenarios also cover the outcome of each path (strap, full upgrade, stuck request, lost link after the change) and the cleanup on restart.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    localparam int SPD_W = 4;
    localparam logic [SPD_W-1:0] SPD_GEN1 = 4'd1;
    localparam logic [SPD_W-1:0] SPD_GEN2 = 4'd2;
    localparam logic [SPD_W-1:0] SPD_NONE = 4'd0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAP,
        ST_WAIT_UP1,
        ST_RAISE,
        ST_WAIT_CHG,
        ST_WAIT_UP2,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        PR_KEEP,
        PR_PASS,
        PR_EXPIRE
    } poll_res_t;

    typedef struct packed {
        logic [SPD_W-1:0] max_spd;
        logic             train_en;
        logic             done;
        logic             err;
        logic [SPD_W-1:0] gen;
    } seq_regs_t;

    // Outcome of one poll slot: pass if the awaited condition holds,
    // expire if this was the final permitted sample.
    function automatic poll_res_t judge_poll(input logic poll,
                                             input logic ok,
                                             input logic last);
        if (!poll) return PR_KEEP;
        if (ok)    return PR_PASS;
        if (last)  return PR_EXPIRE;
        return PR_KEEP;
    endfunction

    function automatic logic is_quiet(input seq_state_t s);
        return (s == ST_IDLE) || (s == ST_DONE) || (s == ST_FAIL);
    endfunction

    function automatic logic is_waiting(input seq_state_t s);
        return (s == ST_WAIT_UP1) || (s == ST_WAIT_CHG) || (s == ST_WAIT_UP2);
    endfunction

endpackage

// File: rtl/lsq_poll_pacer.sv
module lsq_poll_pacer #(
    parameter int POLL_GAP   = 64,
    parameter int POLL_LIMIT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic active_i,
    output logic poll_o,
    output logic last_o
);

    localparam int CW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam logic [CW-1:0] C_LAST = CW'(POLL_LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          slot;

    // Spacing between samples: a free-running divider, or none at all
    // when every cycle is a sample slot.
    generate
        if (POLL_GAP > 1) begin : g_timer
            localparam int TW = $clog2(POLL_GAP);
            localparam logic [TW-1:0] T_WRAP = TW'(POLL_GAP - 1);
            logic [TW-1:0] tmr_q;

            always_ff @(posedge clk) begin
                if (rst || restart_i) begin
                    tmr_q <= '0;
                end else if (active_i) begin
                    tmr_q <= (tmr_q == T_WRAP) ? '0 : tmr_q + 1'b1;
                end
            end
            assign slot = (tmr_q == '0);
        end else begin : g_every
            assign slot = 1'b1;
        end
    endgenerate

    assign poll_o = active_i && slot;
    assign last_o = (cnt_q == C_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (poll_o && !last_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lsq_req_bit.sv
module lsq_req_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic abort_i,
    output logic req_o
);

    // Abort (new sequence) wins, then the set from the sequencer,
    // then the completion clear from the link hardware.
    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            req_o <= 1'b0;
        end else if (set_i) begin
            req_o <= 1'b1;
        end else if (hw_clr_i) begin
            req_o <= 1'b0;
        end
    end

endmodule

// File: rtl/lsq_ctrl.sv
module lsq_ctrl
    import lsq_pkg::*;
#(
    parameter logic [SPD_W-1:0] RESET_SPEED = SPD_GEN2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      force_gen1_i,
    input  logic      link_up_i,
    input  logic      req_i,
    input  logic      poll_i,
    input  logic      last_i,
    output logic      restart_o,
    output logic      active_o,
    output logic      req_set_o,
    output logic      abort_o,
    output seq_regs_t regs_o
);

    seq_state_t st_q, st_d;
    seq_regs_t  r_q, r_d;
    poll_res_t  pr;
    logic       cond;

    always_comb begin
        st_d      = st_q;
        r_d       = r_q;
        abort_o   = 1'b0;
        req_set_o = 1'b0;
        cond      = (st_q == ST_WAIT_CHG) ? !req_i : link_up_i;
        pr        = judge_poll(poll_i, cond, last_i);

        unique case (st_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start_i) begin
                    abort_o    = 1'b1;
                    st_d       = ST_CAP;
                    r_d.max_spd = SPD_GEN1;
                    r_d.train_en = 1'b0;
                    r_d.done   = 1'b0;
                    r_d.err    = 1'b0;
                    r_d.gen    = SPD_NONE;
                end
            end
            ST_CAP: begin
                st_d         = ST_WAIT_UP1;
                r_d.train_en = 1'b1;
            end
            ST_WAIT_UP1: begin
                if (pr == PR_PASS) begin
                    r_d.gen = SPD_GEN1;
                    if (force_gen1_i) begin
                        st_d     = ST_DONE;
                        r_d.done = 1'b1;
                    end else begin
                        st_d        = ST_RAISE;
                        r_d.max_spd = SPD_GEN2;
                    end
                end else if (pr == PR_EXPIRE) begin
                    st_d    = ST_FAIL;
                    r_d.err = 1'b1;
                end
            end
            ST_RAISE: begin
                st_d      = ST_WAIT_CHG;
                req_set_o = 1'b1;
            end
            ST_WAIT_CHG: begin
                if (pr == PR_PASS) begin
                    st_d = ST_WAIT_UP2;
                end else if (pr == PR_EXPIRE) begin
                    st_d    = ST_FAIL;
                    r_d.err = 1'b1;
                end
            end
            ST_WAIT_UP2: begin
                if (pr == PR_PASS) begin
                    st_d     = ST_DONE;
                    r_d.gen  = SPD_GEN2;
                    r_d.done = 1'b1;
                end else if (pr == PR_EXPIRE) begin
                    st_d    = ST_FAIL;
                    r_d.err = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign restart_o = (st_d != st_q);
    assign active_o  = is_waiting(st_q);
    assign regs_o    = r_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_IDLE;
            r_q.max_spd  <= RESET_SPEED;
            r_q.train_en <= 1'b0;
            r_q.done     <= 1'b0;
            r_q.err      <= 1'b0;
            r_q.gen      <= SPD_NONE;
        end else begin
            st_q <= st_d;
            r_q  <= r_d;
        end
    end

endmodule

// File: rtl/speed_bringup_seq.sv
module speed_bringup_seq
    import lsq_pkg::*;
#(
    parameter int               POLL_GAP    = 64,
    parameter int               POLL_LIMIT  = 200,
    parameter logic [SPD_W-1:0] RESET_SPEED = SPD_GEN2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             force_gen1_i,
    input  logic             link_up_i,
    input  logic             spdchg_clr_i,
    output logic [SPD_W-1:0] max_speed_o,
    output logic             train_en_o,
    output logic             spdchg_req_o,
    output logic [SPD_W-1:0] cur_gen_o,
    output logic             done_o,
    output logic             error_o
);

    logic      poll, last, restart, active, req_set, abort;
    seq_regs_t regs;

    lsq_ctrl #(
        .RESET_SPEED(RESET_SPEED)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .force_gen1_i(force_gen1_i),
        .link_up_i   (link_up_i),
        .req_i       (spdchg_req_o),
        .poll_i      (poll),
        .last_i      (last),
        .restart_o   (restart),
        .active_o    (active),
        .req_set_o   (req_set),
        .abort_o     (abort),
        .regs_o      (regs)
    );

    lsq_poll_pacer #(
        .POLL_GAP  (POLL_GAP),
        .POLL_LIMIT(POLL_LIMIT)
    ) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .restart_i(restart),
        .active_i (active),
        .poll_o   (poll),
        .last_o   (last)
    );

    lsq_req_bit u_req (
        .clk     (clk),
        .rst     (rst),
        .set_i   (req_set),
        .hw_clr_i(spdchg_clr_i),
        .abort_i (abort),
        .req_o   (spdchg_req_o)
    );

    assign max_speed_o = regs.max_spd;
    assign train_en_o  = regs.train_en;
    assign cur_gen_o   = regs.gen;
    assign done_o      = regs.done;
    assign error_o     = regs.err;

endmodule

// File: rtl/lsq_checker.sv
module lsq_checker
    import lsq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             force_gen1_i,
    input logic             link_up_i,
    input logic [SPD_W-1:0] max_speed_o,
    input logic             train_en_o,
    input logic             spdchg_req_o,
    input logic [SPD_W-1:0] cur_gen_o,
    input logic             done_o,
    input logic             error_o
);

    assert_cap_first_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(train_en_o) |-> (max_speed_o == SPD_GEN1 && $past(max_speed_o) == SPD_GEN1));

    assert_upgrade_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (max_speed_o == SPD_GEN2 && $past(max_speed_o) != SPD_GEN2)
            |-> ($past(link_up_i) && !$past(force_gen1_i)));

    assert_req_at_gen2_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(spdchg_req_o) |-> (max_speed_o == SPD_GEN2 && cur_gen_o == SPD_GEN1));

    assert_done_needs_link_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(link_up_i));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(done_o && error_o));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

    assert_error_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (error_o && !start_i) |=> error_o);

    assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
        (train_en_o && !done_o && !error_o && start_i) |=> train_en_o);

endmodule

bind speed_bringup_seq lsq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .force_gen1_i(force_gen1_i),
    .link_up_i   (link_up_i),
    .max_speed_o (max_speed_o),
    .train_en_o  (train_en_o),
    .spdchg_req_o(spdchg_req_o),
    .cur_gen_o   (cur_gen_o),
    .done_o      (done_o),
    .error_o     (error_o)
);

// File: tb/sim_speed_bringup_seq.sv
module sim_speed_bringup_seq;

    localparam int GAP   = 2;
    localparam int LIMIT = 200;
    localparam int LAST_OFS = (LIMIT - 1) * GAP;

    typedef struct {
        bit         done;
        bit         err;
        logic [3:0] max;
        logic [3:0] gen;
        bit         req;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       force1 = 1'b0;
    logic       link = 1'b0;
    logic       clr = 1'b0;
    logic [3:0] max_speed, cur_gen;
    logic       train_en, req, done, err;

    int   total = 0;
    int   bad = 0;
    bit   req_seen = 0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    speed_bringup_seq #(
        .POLL_GAP  (GAP),
        .POLL_LIMIT(LIMIT)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .force_gen1_i(force1),
        .link_up_i   (link),
        .spdchg_clr_i(clr),
        .max_speed_o (max_speed),
        .train_en_o  (train_en),
        .spdchg_req_o(req),
        .cur_gen_o   (cur_gen),
        .done_o      (done),
        .error_o     (err)
    );

    task automatic chk_eq(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_end(input bit d, input bit e, input logic [3:0] m,
                              input logic [3:0] g, input bit r, input string tag);
        exp_t x;
        x.done = d; x.err = e; x.max = m; x.gen = g; x.req = r; x.tag = tag;
        sb_q.push_back(x);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_train();
        while (!train_en) @(negedge clk);
    endtask

    task automatic wait_end();
        while (!(done || err)) @(negedge clk);
        @(negedge clk);
    endtask

    // Scoreboard monitor: pops one expected outcome per completion.
    initial begin
        exp_t e;
        bit   prev;
        prev = 0;
        forever begin
            @(negedge clk);
            if (req) req_seen = 1;
            if (!rst && (done || err) && !prev) begin
                if (sb_q.size() == 0) begin
                    chk_eq("R8 unexpected completion", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk_eq({e.tag, " done"}, int'(done), int'(e.done));
                    chk_eq({e.tag, " error"}, int'(err), int'(e.err));
                    chk_eq({e.tag, " max_speed"}, int'(max_speed), int'(e.max));
                    chk_eq({e.tag, " cur_gen"}, int'(cur_gen), int'(e.gen));
                    chk_eq({e.tag, " request"}, int'(req), int'(e.req));
                end
            end
            prev = done || err;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk_eq("watchdog expired", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_eq("R1 max_speed", int'(max_speed), 2);
        chk_eq("R1 train_en", int'(train_en), 0);
        chk_eq("R1 request", int'(req), 0);
        chk_eq("R1 done/error", int'({done, err}), 0);
        chk_eq("R1 cur_gen", int'(cur_gen), 0);

        // Full generation 2 upgrade (R2, R5, R6, R7)
        expect_end(1, 0, 4'd2, 4'd2, 0, "R7 full upgrade");
        pulse_start();
        chk_eq("R2 cap before enable", int'(max_speed), 1);
        chk_eq("R2 enable still low", int'(train_en), 0);
        @(negedge clk);
        chk_eq("R2 enable follows cap", int'(train_en), 1);
        repeat (5) @(negedge clk);
        link = 1'b1;
        while (!req) @(negedge clk);
        chk_eq("R5 raised to gen2", int'(max_speed), 2);
        chk_eq("R5 gen after first up", int'(cur_gen), 1);
        repeat (9) @(negedge clk);
        chk_eq("R6 request held until clear", int'(req), 1);
        clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        wait_end();

        // R8 restart clears sticky flags
        link = 1'b0;
        force1 = 1'b1;
        req_seen = 0;
        expect_end(1, 0, 4'd1, 4'd1, 0, "R4 strap keeps gen1");
        pulse_start();
        chk_eq("R8 done cleared on start", int'(done), 0);
        chk_eq("R8 gen cleared on start", int'(cur_gen), 0);
        // R9 start while busy is ignored
        wait_train();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!train_en || max_speed != 4'd1) n++;
        end
        chk_eq("R9 busy start ignored", n, 0);
        link = 1'b1;
        wait_end();
        chk_eq("R4 no request issued", int'(req_seen), 0);

        // R3 link never comes up: error latency
        link = 1'b0;
        expect_end(0, 1, 4'd1, 4'd0, 0, "R3 first wait timeout");
        pulse_start();
        wait_train();
        n = 0;
        while (!err) begin
            @(negedge clk);
            n++;
        end
        chk_eq("R3 error latency", n, 1 + LAST_OFS);
        wait_end();

        // R10 link-up seen on the final sample
        expect_end(1, 0, 4'd1, 4'd1, 0, "R10 last sample succeeds");
        pulse_start();
        wait_train();
        repeat (LAST_OFS) @(negedge clk);
        link = 1'b1;
        wait_end();

        // R10 one cycle too late
        link = 1'b0;
        expect_end(0, 1, 4'd1, 4'd0, 0, "R10 one cycle late fails");
        pulse_start();
        wait_train();
        repeat (LAST_OFS + 1) @(negedge clk);
        link = 1'b1;
        wait_end();

        // R6 request never cleared
        link = 1'b0;
        force1 = 1'b0;
        expect_end(0, 1, 4'd2, 4'd1, 1, "R6 change timeout");
        pulse_start();
        wait_train();
        link = 1'b1;
        wait_end();
        pulse_start();
        chk_eq("R2 pending request dropped on start", int'(req), 0);

        // R7 link lost after the speed change
        expect_end(0, 1, 4'd2, 4'd1, 0, "R7 second wait timeout");
        link = 1'b1;
        while (!req) @(negedge clk);
        link = 1'b0;
        clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        wait_end();
        chk_eq("R8 error stays set", int'(err), 1);
        chk_eq("R8 flags exclusive", int'(done), 0);

        repeat (3) @(negedge clk);
        chk_eq("scoreboard drained", sb_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule